// File: doc/BRIEF.md
# Host Bus Receive FIFO Burst-Read Port

This block is a read-only slave port on an asynchronous 16-bit host bus. It lets a host stream received data out of a 32-bit-wide FIFO. A sideband select line, usually wired to a high-order address line, marks an access as a FIFO read. While that line is high, the upper address bits are not decoded, and every read cycle returns FIFO contents. The host can therefore increment its address freely through a burst of any length.

Each 32-bit FIFO entry leaves the port as two 16-bit halves. Address bit A1 chooses the half. The entry is consumed only after the upper-half read completes, so a pair of word reads makes up one doubleword.

The active-low chip-select and read strobes are asynchronous to the system clock. They pass through a synchronizer, and an access is live while both are low. Either strobe may rise to close a cycle, so a burst can be framed by toggling either one while the other is held low. The port drives the bus only during a valid read. A read from an empty FIFO raises a sticky underflow flag.

Top module: `hbus_fifo_burst_rd`

## Requirements
- R1: After reset, `bus_oe` is 0, `fifo_pop` is 0 and `rx_underflow` is 0.
- R2: A read with `fifo_sel` high and the FIFO not empty drives `fifo_rdata[15:0]` on `host_data` when A1 (`host_addr[1]`) is 0, and `fifo_rdata[31:16]` when A1 is 1.
- R3: Address bits `host_addr[7:3]` have no effect on the returned data, on popping or on `bus_oe`.
- R4: Completing a FIFO read with A1=1 produces exactly one single-cycle `fifo_pop` pulse. A read with A1=0 never pops, so two word reads consume one entry.
- R5: A cycle is active while both `host_cs_n` and `host_rd_n` are low. Bursts framed by toggling only `host_cs_n`, only `host_rd_n`, or both give the same results, and burst length has no limit.
- R6: `bus_oe` is 1 only during an active read with `fifo_sel` high and the FIFO not empty. The bus is otherwise released to high impedance, and `bus_oe` returns to 0 on the third clock edge after the strobe rises.
- R7: A read with `fifo_sel` low leaves `bus_oe` at 0, does not pop and does not set `rx_underflow`.
- R8: A FIFO read while `fifo_empty` is 1 does not pop and does not drive the bus. It sets `rx_underflow`, which stays 1 through later reads.
- R9: `rx_underflow` returns to 0 on the clock edge after `underflow_clr` is 1, unless a new underflow is detected in that same cycle.
- R10: `bus_oe` and the read data appear on the third rising clock edge after both strobes are low, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| fifo_sel | input | 1 | FIFO-select sideband; high makes the access a FIFO read |
| host_addr | input | 7 | Host address bits A[7:1] |
| host_data | inout | 16 | Host data bus, driven only during a valid FIFO read |
| bus_oe | output | 1 | Data bus output enable (copy of the tristate control) |
| fifo_rdata | input | 32 | Head entry of the receive FIFO (first-word fall-through) |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_pop | output | 1 | One-cycle request to remove the head entry |
| underflow_clr | input | 1 | Synchronous clear of the underflow flag |
| rx_underflow | output | 1 | Sticky flag: a FIFO read found the FIFO empty |

## Verification
The bench sweeps a long burst through several FIFO refills. It rotates among the three framing styles and scatters A[7:3] values across the reads, so it catches a port that decodes upper bits or only honours one strobe. A design that popped on the low-half read, or on both halves, would fall out of step with the bench's own entry index and return the wrong half words. The bench samples one edge before and exactly on the expected edge, which catches an off-by-one synchronizer. It also drains the FIFO and reads again to exercise underflow, stickiness and clearing, and it checks that select-low reads leave the bus released and the FIFO untouched.

// File: rtl/hbus_fifo_pkg.sv
package hbus_fifo_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_START = 2'd1,
    CYC_HOLD  = 2'd2,
    CYC_END   = 2'd3
  } cyc_phase_e;

  // Both strobes low means the host is inside an access.
  function automatic logic strobes_live(input logic cs_n, input logic rd_n);
    return ~cs_n & ~rd_n;
  endfunction

  // Phase from the current and previous live state.
  function automatic cyc_phase_e phase_of(input logic live_now, input logic live_prev);
    case ({live_prev, live_now})
      2'b01:   return CYC_START;
      2'b11:   return CYC_HOLD;
      2'b10:   return CYC_END;
      default: return CYC_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hbus_cycle_detect.sv
module hbus_cycle_detect
  import hbus_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic rd_n_s,
  output logic cyc_active,
  output logic cyc_start,
  output logic cyc_end
);
  logic       live_q;
  cyc_phase_e phase;

  assign cyc_active = strobes_live(cs_n_s, rd_n_s);
  assign phase      = phase_of(cyc_active, live_q);
  assign cyc_start  = (phase == CYC_START);
  assign cyc_end    = (phase == CYC_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= cyc_active;
  end
endmodule

// File: rtl/hbus_read_path.sv
module hbus_read_path #(
  parameter int BUS_W  = 16,
  parameter int WORD_W = 32,
  localparam int HALVES = WORD_W / BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_active,
  input  logic              cyc_start,
  input  logic              cyc_end,
  input  logic              sel_s,
  input  logic              half_hi,
  input  logic [WORD_W-1:0] fifo_rdata,
  input  logic              fifo_empty,
  input  logic              underflow_clr,
  output logic [BUS_W-1:0]  rd_word,
  output logic              oe,
  output logic              pop,
  output logic              underflow,
  output logic              uf_set,
  output logic              take_entry
);
  logic sel_q, hi_q, empty_q;

  function automatic logic [BUS_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                 input logic hi);
    return hi ? w[(HALVES-1)*BUS_W +: BUS_W] : w[0 +: BUS_W];
  endfunction

  assign uf_set     = cyc_start & sel_s & fifo_empty;
  assign take_entry = cyc_end & sel_q & ~empty_q & hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      hi_q    <= 1'b0;
      empty_q <= 1'b1;
      rd_word <= '0;
    end else if (cyc_start) begin
      sel_q   <= sel_s;
      hi_q    <= half_hi;
      empty_q <= fifo_empty;
      rd_word <= (sel_s & ~fifo_empty) ? pick_half(fifo_rdata, half_hi) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          oe <= 1'b0;
    else if (!cyc_active) oe <= 1'b0;
    else if (cyc_start)  oe <= sel_s & ~fifo_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pop <= 1'b0;
    else        pop <= take_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             underflow <= 1'b0;
    else if (uf_set)        underflow <= 1'b1;
    else if (underflow_clr) underflow <= 1'b0;
  end
endmodule

// File: rtl/hbus_fifo_burst_rd.sv
module hbus_fifo_burst_rd #(
  parameter int BUS_W       = 16,
  parameter int WORD_W      = 32,
  parameter int ADDR_HI     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              fifo_sel,
  input  logic [ADDR_HI:1]  host_addr,
  inout  wire  [BUS_W-1:0]  host_data,
  output logic              bus_oe,
  input  logic [WORD_W-1:0] fifo_rdata,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic              underflow_clr,
  output logic              rx_underflow
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] raw_ctl, sync_ctl;
  logic cs_n_s, rd_n_s, sel_s;
  logic cyc_active, cyc_start, cyc_end;
  logic uf_set, take_entry;
  logic half_hi;
  logic [BUS_W-1:0] rd_word;

  assign raw_ctl = {fifo_sel, host_rd_n, host_cs_n};

  hbus_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_ctl), .q_sync(sync_ctl)
  );

  assign cs_n_s = sync_ctl[0];
  assign rd_n_s = sync_ctl[1];
  assign sel_s  = sync_ctl[2];

  // Only A1 chooses the half; the address is stable by the time the
  // synchronized strobe edge arrives, so it is sampled directly.
  assign half_hi = host_addr[1];

  hbus_cycle_detect u_cyc (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .rd_n_s(rd_n_s),
    .cyc_active(cyc_active), .cyc_start(cyc_start), .cyc_end(cyc_end)
  );

  hbus_read_path #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .cyc_active(cyc_active), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .sel_s(sel_s), .half_hi(half_hi),
    .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
    .underflow_clr(underflow_clr),
    .rd_word(rd_word), .oe(bus_oe), .pop(fifo_pop),
    .underflow(rx_underflow), .uf_set(uf_set), .take_entry(take_entry)
  );

  assign host_data = bus_oe ? rd_word : {BUS_W{1'bz}};
endmodule

module hbus_fifo_burst_rd_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_active,
  input logic cyc_start,
  input logic cyc_end,
  input logic sel_s,
  input logic fifo_empty,
  input logic bus_oe,
  input logic fifo_pop,
  input logic uf_set,
  input logic underflow_clr,
  input logic rx_underflow
);
  AST_POP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop); // R4
  AST_POP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> $past(cyc_end)); // R4
  AST_OE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(cyc_active)); // R6
  AST_SEL_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !sel_s) |=> !bus_oe); // R7
  AST_EMPTY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && fifo_empty) |=> !bus_oe); // R8
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_underflow && !underflow_clr) |=> rx_underflow); // R8
  AST_UF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_clr && !uf_set) |=> !rx_underflow); // R9
  AST_UF_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_underflow) |-> $past(uf_set)); // R8
endmodule

bind hbus_fifo_burst_rd hbus_fifo_burst_rd_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .cyc_active(cyc_active), .cyc_start(cyc_start), .cyc_end(cyc_end),
  .sel_s(sel_s), .fifo_empty(fifo_empty), .bus_oe(bus_oe),
  .fifo_pop(fifo_pop), .uf_set(uf_set), .underflow_clr(underflow_clr),
  .rx_underflow(rx_underflow)
);

// File: tb/sim_hbus_fifo_burst_rd.sv
module sim_hbus_fifo_burst_rd;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, sel = 1'b0, clr = 1'b0;
  logic [7:1] addr = '0;
  wire  [15:0] hd;
  logic oe, pop, uf, empty;
  logic [31:0] rdata;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, exp_idx = 0;
  logic [31:0] fmem [16];

  always #(CLK_P/2) clk = ~clk;

  hbus_fifo_burst_rd u0 (
    .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_rd_n(rd_n),
    .fifo_sel(sel), .host_addr(addr), .host_data(hd), .bus_oe(oe),
    .fifo_rdata(rdata), .fifo_empty(empty), .fifo_pop(pop),
    .underflow_clr(clr), .rx_underflow(uf)
  );

  assign empty = (wr_cnt == rd_cnt);
  assign rdata = fmem[rd_cnt % 16];

  always @(posedge clk) if (pop) rd_cnt <= rd_cnt + 1;

  function automatic logic [31:0] pat(input int k);
    return 32'hA5C3_0000 ^ (32'(k) * 32'h0101_0F1B);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int k);
    fmem[wr_cnt % 16] = pat(k);
    wr_cnt = wr_cnt + 1;
  endtask

  // mode 0: both strobes toggle; 1: cs toggles, rd held low; 2: rd toggles, cs held low
  task automatic hold_other(input int mode);
    @(negedge clk);
    if (mode == 1) rd_n = 1'b0;
    if (mode == 2) cs_n = 1'b0;
  endtask

  task automatic one_read(input int mode, input logic s, input logic [7:1] a,
                          input logic exp_oe, input logic [15:0] exp_d,
                          input logic exp_pop, input string tag);
    @(negedge clk);
    sel = s; addr = a;
    if (mode != 2) cs_n = 1'b0;
    if (mode != 1) rd_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk({31'd0, oe}, 32'd0, {tag, " R10 early oe"});
    @(posedge clk); @(negedge clk);
    chk({31'd0, oe}, {31'd0, exp_oe}, {tag, " R6 oe"});
    if (exp_oe) chk({16'd0, hd}, {16'd0, exp_d}, {tag, " R2 data"});
    @(posedge clk); @(negedge clk);
    if (mode != 2) cs_n = 1'b1;
    if (mode != 1) rd_n = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk({31'd0, pop}, {31'd0, exp_pop}, {tag, " R4 pop"});
    chk({31'd0, oe}, 32'd0, {tag, " R6 release"});
    @(posedge clk); @(negedge clk);
    chk({31'd0, pop}, 32'd0, {tag, " R4 single pulse"});
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({29'd0, oe, pop, uf}, 32'd0, "R1 reset state");

    // Sweep: 40 entries, 80 word reads, varied framing and A[7:3].
    for (int blk = 0; blk < 5; blk++) begin
      for (int j = 0; j < 8; j++) push(blk * 8 + j);
      for (int j = 0; j < 8; j++) begin
        int k = blk * 8 + j;
        int mode = k % 3;
        logic [7:3] up_lo = 5'((k * 7) % 32);
        logic [7:3] up_hi = 5'((k * 13 + 5) % 32);
        hold_other(mode);
        one_read(mode, 1'b1, {up_lo, 2'b00}, 1'b1, pat(exp_idx)[15:0], 1'b0, "R3 R5 lo");
        one_read(mode, 1'b1, {up_hi, 2'b01}, 1'b1, pat(exp_idx)[31:16], 1'b1, "R3 R5 hi");
        exp_idx++;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
      end
    end
    chk(32'(rd_cnt), 32'(wr_cnt), "R4 two words per entry");

    // Select low with data present: no drive, no pop, no underflow.
    push(100);
    one_read(0, 1'b0, 7'h7F, 1'b0, 16'h0, 1'b0, "R7 sel low");
    chk({31'd0, uf}, 32'd0, "R7 no underflow");
    chk({31'd0, empty}, 32'd0, "R7 entry kept");
    one_read(0, 1'b1, 7'h01, 1'b1, pat(100)[31:16], 1'b1, "R2 hi first");

    // Empty reads.
    one_read(0, 1'b1, 7'h00, 1'b0, 16'h0, 1'b0, "R8 empty lo");
    chk({31'd0, uf}, 32'd1, "R8 underflow set");
    one_read(1, 1'b1, 7'h01, 1'b0, 16'h0, 1'b0, "R8 empty hi");
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({31'd0, uf}, 32'd1, "R8 sticky");
    clr = 1'b1;
    @(posedge clk); @(negedge clk);
    clr = 1'b0;
    chk({31'd0, uf}, 32'd0, "R9 cleared");

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule